// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter with Inter-Processor Interrupt

This block sits beside one processor and decides which single interrupt, if any, is presented to it. It keeps the processor's current priority, an inter-processor interrupt (IPI) priority, and one pending slot. The pending slot holds a source number and that source's priority. A flag records that an offered interrupt was turned away and must be offered again later.

The processor drives a one-cycle command port with one of four operations:
- accept the pending interrupt;
- change its current priority;
- change the IPI priority;
- signal end of interrupt.

An external source controller offers interrupts through a present port. The block drives a level interrupt request back to the processor. It also drives two one-cycle strobes toward the source controller. The first names an interrupt that was displaced or refused, so it can be delivered again. The second asks for pending re-offers to be resent.

Priorities are 8 bits, and a smaller number is more favored. Source number 0 means no interrupt. The IPI uses a reserved source number, set by a parameter.

Every command or offer is sampled on a rising clock edge, and its effects are registered. The response word and both strobes are therefore valid for exactly one cycle, the cycle after the sampling edge. The interrupt request follows the registered state.

Top module: `intr_presenter`

## Requirements
- R1: After reset, the current priority is 0x00, the IPI priority is 0xFF and the pending slot is empty. An empty slot always has source 0 and pending priority 0xFF.
- R2: `irq_out` is high exactly when the pending source is nonzero and the pending priority is numerically less than the current priority.
- R3: Accept (op 0) returns a response word with the current priority in bits 31:24 and the pending source in bits 23:0.
  - If the pending source was nonzero, the current priority takes the pending priority and the slot empties.
  - Otherwise the state is unchanged.
- R4: Set IPI priority (op 2, value in `cmd_data[7:0]`) stores the value. If the value is below the current priority, the slot takes the IPI source at that priority. The displaced source is rejected only when the value is less than or equal to the old pending priority.
- R5: When set IPI priority moves the value above both its old value and the current priority, a set need-resend flag produces a resend strobe and is cleared.
- R6: Set current priority (op 1, value in `cmd_data[7:0]`) behaves as follows:
  - A value equal to the current priority changes nothing.
  - A smaller value is stored. If it is also less than or equal to the pending priority, the pending source is rejected and the slot empties.
- R7: Set current priority to a larger value lowers it:
  - The new priority is loaded.
  - The IPI is installed at the IPI priority if that priority is below the new current priority and at most the pending priority.
  - A set need-resend flag is emitted as a resend strobe and cleared.
- R8: End of interrupt (op 3) lowers the current priority to `cmd_data[31:24]` in the same way as R7. If `cmd_data[23:0]` is not the IPI source and `src_asserted` is high, that source is sent out on the reject strobe.
- R9: The reject strobe never carries source 0 or the IPI source.
- R10: An offer with no command in the same cycle is handled as follows:
  - It is taken when its priority is below both the current and the pending priority, and any displaced source is rejected.
  - Otherwise it sets need-resend and is echoed on the reject strobe.
- R11: An offer of source 0 or the IPI source is ignored. An offer made in a command cycle is discarded and sets need-resend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 accept, 1 set current priority, 2 set IPI priority, 3 end of interrupt |
| cmd_data | input | 32 | Priority value in bits 7:0, or the response-format word for end of interrupt |
| src_asserted | input | 1 | Level of the source named in an end-of-interrupt command |
| offer_valid | input | 1 | Source controller offers an interrupt |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| irq_out | output | 1 | Interrupt request to the processor |
| rsp_valid | output | 1 | Accept response valid |
| rsp_xirr | output | 32 | Accept response: priority in bits 31:24, source in bits 23:0 |
| reject_valid | output | 1 | Reject strobe |
| reject_src | output | 24 | Source to be delivered again |
| resend_req | output | 1 | Resend strobe |

## Verification
The pending slot is driven by three competitors:
- offers that win on priority;
- offers that lose on priority;
- IPI-priority writes above, between and below the pending priority.

These cases separate a plain replacement from a replacement that also rejects the old source. Current-priority writes are tried equal, slightly raised (no reject), raised to the pending priority (reject) and lowered. These separate the no-op, store-only, reject and lower paths. End of interrupt is applied to the IPI source and to a real source, each with `src_asserted` high, which shows that only real sources are re-delivered. Refused and same-cycle offers then show the need-resend flag coming out at the next lowering of the current priority.

// File: rtl/intr_pres_pkg.sv
package intr_pres_pkg;
  localparam int PRIO_W = 8;
  localparam int SRC_W  = 24;
  localparam int XIRR_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  typedef enum logic [1:0] {
    OP_ACCEPT   = 2'd0,
    OP_SET_CPPR = 2'd1,
    OP_SET_MFRR = 2'd2,
    OP_EOI      = 2'd3
  } pres_op_e;

  typedef struct packed {
    logic [PRIO_W-1:0] cppr;
    logic [PRIO_W-1:0] mfrr;
    logic [PRIO_W-1:0] prio;
    logic [SRC_W-1:0]  xisr;
    logic              need_resend;
  } pres_state_t;
endpackage

// File: rtl/intr_pres_lower.sv
module intr_pres_lower
  import intr_pres_pkg::*;
#(
  parameter int unsigned IPI_SRC = 2
) (
  input  pres_state_t       cur,
  input  logic [PRIO_W-1:0] new_cppr,
  output pres_state_t       nxt,
  output logic              resend
);
  localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_SRC);

  always_comb begin
    nxt      = cur;
    nxt.cppr = new_cppr;
    if ((cur.mfrr < new_cppr) && (cur.mfrr <= cur.prio)) begin
      nxt.prio = cur.mfrr;
      nxt.xisr = IPI_ID;
    end
    resend          = cur.need_resend;
    nxt.need_resend = 1'b0;
  end
endmodule

// File: rtl/intr_pres_next.sv
module intr_pres_next
  import intr_pres_pkg::*;
#(
  parameter int unsigned IPI_SRC = 2
) (
  input  pres_state_t       cur,
  input  logic              cmd_valid,
  input  pres_op_e          cmd_op,
  input  logic [XIRR_W-1:0] cmd_data,
  input  logic              src_asserted,
  input  pres_state_t       low_state,
  input  logic              low_resend,
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  output pres_state_t       nxt,
  output logic              rej_v,
  output logic [SRC_W-1:0]  rej_src,
  output logic              resend_v,
  output logic              rsp_v,
  output logic [XIRR_W-1:0] rsp_word
);
  localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] val;
  logic [SRC_W-1:0]  eoi_src;
  logic [SRC_W-1:0]  rej_cand;
  logic              offer_ok;

  assign val      = cmd_data[PRIO_W-1:0];
  assign eoi_src  = cmd_data[SRC_W-1:0];
  assign offer_ok = offer_valid && (offer_src != '0) && (offer_src != IPI_ID);

  always_comb begin
    nxt      = cur;
    rej_cand = '0;
    resend_v = 1'b0;
    rsp_v    = 1'b0;
    rsp_word = {cur.cppr, cur.xisr};
    if (cmd_valid) begin
      unique case (cmd_op)
        OP_ACCEPT: begin
          rsp_v = 1'b1;
          if (cur.xisr != '0) begin
            nxt.cppr = cur.prio;
            nxt.prio = PRIO_NONE;
            nxt.xisr = '0;
          end
        end
        OP_SET_CPPR: begin
          if (val > cur.cppr) begin
            nxt      = low_state;
            resend_v = low_resend;
          end else if (val < cur.cppr) begin
            nxt.cppr = val;
            if (val <= cur.prio) begin
              rej_cand = cur.xisr;
              nxt.xisr = '0;
              nxt.prio = PRIO_NONE;
            end
          end
        end
        OP_SET_MFRR: begin
          nxt.mfrr = val;
          if (val < cur.cppr) begin
            if (val <= cur.prio) rej_cand = cur.xisr;
            nxt.prio = val;
            nxt.xisr = IPI_ID;
          end
          if ((val > cur.mfrr) && (val > cur.cppr)) begin
            resend_v        = cur.need_resend;
            nxt.need_resend = 1'b0;
          end
        end
        OP_EOI: begin
          nxt      = low_state;
          resend_v = low_resend;
          if ((eoi_src != IPI_ID) && src_asserted) rej_cand = eoi_src;
        end
        default: ;
      endcase
    end
    if (offer_ok) begin
      if (cmd_valid) begin
        nxt.need_resend = 1'b1;
      end else if ((offer_prio < cur.cppr) && (offer_prio < cur.prio)) begin
        rej_cand = cur.xisr;
        nxt.xisr = offer_src;
        nxt.prio = offer_prio;
      end else begin
        nxt.need_resend = 1'b1;
        rej_cand        = offer_src;
      end
    end
    rej_v   = (rej_cand != '0) && (rej_cand != IPI_ID);
    rej_src = rej_cand;
  end
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
  import intr_pres_pkg::*;
#(
  parameter int unsigned IPI_SRC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [XIRR_W-1:0] cmd_data,
  input  logic              src_asserted,
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  output logic              irq_out,
  output logic              rsp_valid,
  output logic [XIRR_W-1:0] rsp_xirr,
  output logic              reject_valid,
  output logic [SRC_W-1:0]  reject_src,
  output logic              resend_req
);
  localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_SRC);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  pres_op_e          op;
  pres_state_t       state_q, state_d, low_state;
  logic              low_resend;
  logic [PRIO_W-1:0] low_val;
  logic              rej_v, resend_v, rsp_v;
  logic [SRC_W-1:0]  rej_src;
  logic [XIRR_W-1:0] rsp_word;
  logic              state_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign op       = pres_op_e'(cmd_op);
  assign low_val  = (op == OP_EOI) ? cmd_data[XIRR_W-1:SRC_W] : cmd_data[PRIO_W-1:0];
  assign state_en = cmd_valid || offer_valid;

  intr_pres_lower #(.IPI_SRC(IPI_SRC)) u_lower (
    .cur(state_q), .new_cppr(low_val), .nxt(low_state), .resend(low_resend)
  );

  intr_pres_next #(.IPI_SRC(IPI_SRC)) u_next (
    .cur(state_q), .cmd_valid(cmd_valid), .cmd_op(op), .cmd_data(cmd_data),
    .src_asserted(src_asserted), .low_state(low_state), .low_resend(low_resend),
    .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
    .nxt(state_d), .rej_v(rej_v), .rej_src(rej_src), .resend_v(resend_v),
    .rsp_v(rsp_v), .rsp_word(rsp_word)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q.cppr        <= '0;
      state_q.mfrr        <= PRIO_NONE;
      state_q.prio        <= PRIO_NONE;
      state_q.xisr        <= '0;
      state_q.need_resend <= 1'b0;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid    <= 1'b0;
      rsp_xirr     <= '0;
      reject_valid <= 1'b0;
      reject_src   <= '0;
      resend_req   <= 1'b0;
    end else begin
      rsp_valid    <= rsp_v;
      reject_valid <= rej_v;
      resend_req   <= resend_v;
      if (rsp_v) rsp_xirr   <= rsp_word;
      if (rej_v) reject_src <= rej_src;
    end
  end

  assign irq_out = (state_q.xisr != '0) && (state_q.prio < state_q.cppr);

  p_empty_slot_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q.xisr == '0) |-> (state_q.prio == PRIO_NONE));

  p_accept_drops_irq_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && (rsp_xirr[SRC_W-1:0] != '0)) |-> !irq_out);

  p_mfrr_ipi_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && (op == OP_SET_MFRR) && (cmd_data[PRIO_W-1:0] < state_q.cppr)) |=> irq_out);

  p_cppr_same_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && (op == OP_SET_CPPR) && (cmd_data[PRIO_W-1:0] == state_q.cppr) && !offer_valid)
    |=> ($stable(state_q) && !reject_valid && !resend_req));

  p_reject_filter_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    reject_valid |-> ((reject_src != '0) && (reject_src != IPI_ID)));
endmodule

// File: tb/intr_presenter_tb.sv
module intr_presenter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_data = '0;
  logic        src_asserted = 1'b0;
  logic        offer_valid = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        irq_out, rsp_valid, reject_valid, resend_req;
  logic [31:0] rsp_xirr;
  logic [23:0] reject_src;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;

  always #4 clk = ~clk;

  intr_presenter u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .src_asserted(src_asserted), .offer_valid(offer_valid),
    .offer_src(offer_src), .offer_prio(offer_prio), .irq_out(irq_out),
    .rsp_valid(rsp_valid), .rsp_xirr(rsp_xirr), .reject_valid(reject_valid),
    .reject_src(reject_src), .resend_req(resend_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
    end
  end

  // drive at negedge, results visible at the following negedge
  task automatic cmd(input logic [1:0] op, input logic [31:0] d, input logic asrt);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; src_asserted = asrt;
    @(negedge clk);
    cmd_valid = 1'b0; src_asserted = 1'b0;
  endtask

  task automatic offer(input logic [23:0] s, input logic [7:0] p);
    @(negedge clk);
    offer_valid = 1'b1; offer_src = s; offer_prio = p;
    @(negedge clk);
    offer_valid = 1'b0;
  endtask

  task automatic accept_exp(input string tag, input logic [31:0] exp);
    cmd(2'd0, 32'h0, 1'b0);
    chk({tag, " rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
    chk({tag, " xirr"}, rsp_xirr, exp);
  endtask

  task automatic strobes(input string tag, input logic rv, input logic [23:0] rs, input logic rq);
    chk({tag, " reject_valid"}, {31'b0, reject_valid}, {31'b0, rv});
    if (rv) chk({tag, " reject_src"}, {8'b0, reject_src}, {8'b0, rs});
    chk({tag, " resend_req"}, {31'b0, resend_req}, {31'b0, rq});
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", {31'b0, irq_out}, 32'd0);
    strobes("R1 reset", 1'b0, 24'h0, 1'b0);
    accept_exp("R1 R3 empty accept", 32'h0000_0000);
    accept_exp("R3 empty accept unchanged", 32'h0000_0000);
  endtask

  task automatic t_offer_and_eoi();
    cmd(2'd1, 32'hFF, 1'b0);
    strobes("R7 lower no resend", 1'b0, 24'h0, 1'b0);
    offer(24'h123, 8'h40);
    chk("R10 R2 offer taken irq", {31'b0, irq_out}, 32'd1);
    accept_exp("R3 accept real", 32'hFF00_0123);
    chk("R3 R2 irq after accept", {31'b0, irq_out}, 32'd0);
    offer(24'h55, 8'h50);
    strobes("R10 refused echo", 1'b1, 24'h55, 1'b0);
    cmd(2'd3, 32'hFF00_0123, 1'b0);
    strobes("R8 R7 eoi resend", 1'b0, 24'h0, 1'b1);
    accept_exp("R8 eoi restored", 32'hFF00_0000);
  endtask

  task automatic t_mfrr();
    offer(24'h77, 8'h30);
    cmd(2'd2, 32'h20, 1'b0);
    strobes("R4 mfrr reject", 1'b1, 24'h77, 1'b0);
    chk("R4 R2 ipi irq", {31'b0, irq_out}, 32'd1);
    accept_exp("R4 ipi accept", 32'hFF00_0002);
    cmd(2'd3, 32'hFF00_0002, 1'b1);
    strobes("R8 R9 ipi eoi no reject", 1'b0, 24'h0, 1'b0);
    chk("R7 ipi reinstalled", {31'b0, irq_out}, 32'd1);
    accept_exp("R7 ipi again", 32'hFF00_0002);
    offer(24'h99, 8'h60);
    strobes("R10 refused at cppr 20", 1'b1, 24'h99, 1'b0);
    cmd(2'd2, 32'hFF, 1'b0);
    strobes("R5 mfrr raise resend", 1'b0, 24'h0, 1'b1);
    cmd(2'd3, 32'hFF00_0002, 1'b0);
    strobes("R5 flag cleared", 1'b0, 24'h0, 1'b0);
    offer(24'h44, 8'h10);
    cmd(2'd2, 32'h30, 1'b0);
    strobes("R4 mfrr less favored no reject", 1'b0, 24'h0, 1'b0);
    accept_exp("R4 ipi replaced slot", 32'hFF00_0002);
    cmd(2'd2, 32'hFF, 1'b0);
    cmd(2'd3, 32'hFF00_0002, 1'b0);
    accept_exp("R4 clean", 32'hFF00_0000);
  endtask

  task automatic t_cppr();
    offer(24'h10, 8'h80);
    cmd(2'd1, 32'hFF, 1'b0);
    strobes("R6 equal noop", 1'b0, 24'h0, 1'b0);
    chk("R6 equal irq kept", {31'b0, irq_out}, 32'd1);
    cmd(2'd1, 32'h90, 1'b0);
    strobes("R6 raise no reject", 1'b0, 24'h0, 1'b0);
    chk("R6 R2 irq kept", {31'b0, irq_out}, 32'd1);
    cmd(2'd1, 32'h80, 1'b0);
    strobes("R6 raise reject", 1'b1, 24'h10, 1'b0);
    chk("R6 irq dropped", {31'b0, irq_out}, 32'd0);
    accept_exp("R6 R1 slot empty", 32'h8000_0000);
  endtask

  task automatic t_eoi_asserted();
    offer(24'h200, 8'h05);
    accept_exp("R8 accept 200", 32'h8000_0200);
    cmd(2'd3, 32'h8000_0200, 1'b1);
    strobes("R8 asserted resent", 1'b1, 24'h200, 1'b0);
    accept_exp("R8 cppr back", 32'h8000_0000);
  endtask

  task automatic t_ignored();
    offer(24'h0, 8'h01);
    strobes("R11 src0 ignored", 1'b0, 24'h0, 1'b0);
    offer(24'h2, 8'h01);
    strobes("R11 ipi src ignored", 1'b0, 24'h0, 1'b0);
    accept_exp("R11 nothing pending", 32'h8000_0000);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = '0;
    offer_valid = 1'b1; offer_src = 24'h300; offer_prio = 8'h01;
    @(negedge clk);
    cmd_valid = 1'b0; offer_valid = 1'b0;
    strobes("R11 same cycle discarded", 1'b0, 24'h0, 1'b0);
    chk("R11 same cycle irq", {31'b0, irq_out}, 32'd0);
    cmd(2'd1, 32'hFF, 1'b0);
    strobes("R11 R7 flag set", 1'b0, 24'h0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_offer_and_eoi();
    t_mfrr();
    t_cppr();
    t_eoi_asserted();
    t_ignored();
    summary();
  end
endmodule